// File: doc/BRIEF.md
# Configurable Address Latch Controller

This block sits between a target's memory strobes and an emulation SRAM. It decides when to freeze the address bus, and optionally the two byte-enable lines, that reach the SRAM. It takes active-low chip-select, output-enable and write-enable strobes, which have already been filtered. When the selected trigger condition is met, it captures the address after an optional settle delay and holds it until the condition drops. While no hold is active, the address and byte enables pass straight through.

There are four trigger conditions. One of them freezes as early as chip-select and lets go again when output-enable arrives, so that reads with steady strobes still see address changes. A write always triggers a freeze, whichever condition is selected. The configuration inputs are copied into an internal configuration register only while the block is idle, so a hold in progress always finishes under the rules that started it.

After reset the configuration register holds these defaults:
- trigger condition: chip-select with write-enable;
- settle delay: enabled, at its minimum value;
- byte-enable latching: enabled.

Top module: `addr_latch_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, hold_o is 0 and addr_o and be_no follow addr_i and be_ni.
- R2: Whenever hold_o is 0, addr_o equals addr_i and be_no equals be_ni in the same cycle.
- R3: While hold_o is 1, addr_o keeps the value captured at the freeze edge, whatever addr_i does.
- R4: mode 2'b00 (reset default) triggers on cs_ni=0 and we_ni=0 together; cs_ni=0 with only oe_ni=0 does not freeze.
- R5: mode 2'b01 triggers on cs_ni=0 alone.
- R6: mode 2'b10 triggers on cs_ni=0 with either we_ni=0 or oe_ni=0.
- R7: mode 2'b11 triggers on cs_ni=0 while oe_ni=1, and a hold is released when oe_ni goes to 0.
- R8: cs_ni=0 with we_ni=0 triggers a freeze in every mode, including mode 2'b11 with oe_ni=0.
- R9: With dly_en_i=1 the freeze (capture of addr_i and hold_o rising) happens at the Nth clock edge after the edge that first samples the trigger, where N is dly_i, and a dly_i of 0 counts as 1. With dly_en_i=0 it happens at the edge that first samples the trigger.
- R10: If the trigger drops before the delay expires, no freeze happens.
- R11: When the trigger condition drops during a hold, hold_o falls at the next clock edge and the outputs become transparent from then on.
- R12: With be_latch_en_i=1 (reset default), be_no freezes together with the address. With be_latch_en_i=0, be_no stays transparent during a hold.
- R13: mode_i, dly_en_i, dly_i and be_latch_en_i are loaded only at an edge where no hold or delay is in progress and no trigger is present. Each new value applies from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Filtered chip-select, active low |
| oe_ni | input | 1 | Filtered output-enable, active low |
| we_ni | input | 1 | Filtered write-enable, active low |
| mode_i | input | 2 | Trigger condition selector |
| dly_en_i | input | 1 | Settle delay enable |
| dly_i | input | DLY_W | Settle delay in clock cycles |
| be_latch_en_i | input | 1 | Include byte enables in the freeze |
| addr_i | input | ADDR_W | Address from the target |
| be_ni | input | 2 | Byte enables from the target, active low |
| addr_o | output | ADDR_W | Address to the SRAM, frozen or transparent |
| be_no | output | 2 | Byte enables to the SRAM, frozen or transparent |
| hold_o | output | 1 | High while the freeze is active |

## Verification
If the sequencer state is wrong, hold_o rises one or more edges early or late relative to the programmed delay. It can also fail to fall on the edge after the trigger drops. Either error shows up as addr_o failing to track addr_i, or tracking it when it should not, in the first cycle of the mismatch. A stale or wrongly loaded configuration register only becomes visible on the next trigger: that trigger freezes, or fails to freeze, under the wrong condition. The bench therefore changes the configuration during a hold and then probes the first trigger afterwards.

// File: rtl/afc_pkg.sv
package afc_pkg;
  localparam int unsigned DLY_W = 3;

  typedef enum logic [1:0] {
    TRIG_CS_WE     = 2'd0,
    TRIG_CS        = 2'd1,
    TRIG_CS_ANY    = 2'd2,
    TRIG_CS_NOT_OE = 2'd3
  } trig_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_HOLD = 2'd2
  } seq_st_e;
endpackage

// File: rtl/afc_trig.sv
module afc_trig
  import afc_pkg::*;
(
  input  logic       cs_ni,
  input  logic       oe_ni,
  input  logic       we_ni,
  input  trig_mode_e mode_i,
  output logic       trig_o
);
  logic cs, oe, we, base;

  assign cs = ~cs_ni;
  assign oe = ~oe_ni;
  assign we = ~we_ni;

  always_comb begin
    unique case (mode_i)
      TRIG_CS_WE:  base = cs & we;
      TRIG_CS:     base = cs;
      TRIG_CS_ANY: base = cs & (we | oe);
      default:     base = cs & ~oe;
    endcase
  end

  // a write always freezes, whatever the mode
  assign trig_o = base | (cs & we);
endmodule

// File: rtl/afc_cfg.sv
module afc_cfg
  import afc_pkg::*;
#(
  parameter int unsigned DW = DLY_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [1:0]    mode_i,
  input  logic          dly_en_i,
  input  logic [DW-1:0] dly_i,
  input  logic          be_en_i,
  output trig_mode_e    mode_o,
  output logic          dly_en_o,
  output logic [DW-1:0] dly_o,
  output logic          be_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o   <= TRIG_CS_WE;
      dly_en_o <= 1'b1;
      dly_o    <= '0;
      be_en_o  <= 1'b1;
    end else if (load_i) begin
      mode_o   <= trig_mode_e'(mode_i);
      dly_en_o <= dly_en_i;
      dly_o    <= dly_i;
      be_en_o  <= be_en_i;
    end
  end

  AST_CFG_FROZEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(mode_o) && $stable(dly_en_o) && $stable(dly_o) && $stable(be_en_o))); // R13
endmodule

// File: rtl/afc_seq.sv
module afc_seq
  import afc_pkg::*;
#(
  parameter int unsigned DW = DLY_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trig_i,
  input  logic          dly_en_i,
  input  logic [DW-1:0] dly_i,
  output logic          idle_o,
  output logic          cap_o,
  output logic          hold_o
);
  seq_st_e       st_q, st_d;
  logic [DW-1:0] cnt_q, cnt_d, dly_eff;

  assign dly_eff = (dly_i == '0) ? DW'(1) : dly_i;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    cap_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (trig_i) begin
          if (dly_en_i) begin
            st_d  = ST_ARM;
            cnt_d = dly_eff;
          end else begin
            st_d  = ST_HOLD;
            cap_o = 1'b1;
          end
        end
      end
      ST_ARM: begin
        if (!trig_i) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end else if (cnt_q == DW'(1)) begin
          st_d  = ST_HOLD;
          cnt_d = '0;
          cap_o = 1'b1;
        end else begin
          cnt_d = cnt_q - DW'(1);
        end
      end
      ST_HOLD: begin
        if (!trig_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign hold_o = (st_q == ST_HOLD);
  assign idle_o = (st_q == ST_IDLE) && !trig_i;

  AST_ARM_CNT_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ARM) |-> (cnt_q != '0)); // R9
  AST_ARM_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ARM && !trig_i) |=> (st_q == ST_IDLE)); // R10
  AST_HOLD_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && !trig_i) |=> !hold_o); // R11
  AST_HOLD_FROM_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> $past(trig_i)); // R9
endmodule

// File: rtl/afc_capture.sv
module afc_capture #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned BE_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              hold_i,
  input  logic              be_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_ni,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BE_W-1:0]   be_no
);
  logic [ADDR_W-1:0] addr_q;
  logic [BE_W-1:0]   be_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      be_q   <= '1;
    end else if (cap_i) begin
      addr_q <= addr_i;
      be_q   <= be_ni;
    end
  end

  assign addr_o = hold_i ? addr_q : addr_i;

  for (genvar g = 0; g < BE_W; g++) begin : g_be_lane
    assign be_no[g] = (hold_i && be_en_i) ? be_q[g] : be_ni[g];
  end

  AST_NO_RECAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |-> !cap_i); // R3
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !cap_i) |=> (!hold_i || addr_o == $past(addr_o))); // R3
endmodule

// File: rtl/addr_latch_ctrl.sv
module addr_latch_ctrl
  import afc_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DW     = DLY_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [1:0]        mode_i,
  input  logic              dly_en_i,
  input  logic [DW-1:0]     dly_i,
  input  logic              be_latch_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        be_ni,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        be_no,
  output logic              hold_o
);
  trig_mode_e    mode_q;
  logic          dly_en_q, be_en_q, trig, idle, cap;
  logic [DW-1:0] dly_q;

  afc_cfg #(.DW(DW)) u_cfg (
    .clk_i, .rst_ni,
    .load_i   (idle),
    .mode_i   (mode_i),
    .dly_en_i (dly_en_i),
    .dly_i    (dly_i),
    .be_en_i  (be_latch_en_i),
    .mode_o   (mode_q),
    .dly_en_o (dly_en_q),
    .dly_o    (dly_q),
    .be_en_o  (be_en_q)
  );

  afc_trig u_trig (
    .cs_ni, .oe_ni, .we_ni,
    .mode_i (mode_q),
    .trig_o (trig)
  );

  afc_seq #(.DW(DW)) u_seq (
    .clk_i, .rst_ni,
    .trig_i   (trig),
    .dly_en_i (dly_en_q),
    .dly_i    (dly_q),
    .idle_o   (idle),
    .cap_o    (cap),
    .hold_o   (hold_o)
  );

  afc_capture #(.ADDR_W(ADDR_W), .BE_W(2)) u_cap (
    .clk_i, .rst_ni,
    .cap_i   (cap),
    .hold_i  (hold_o),
    .be_en_i (be_en_q),
    .addr_i  (addr_i),
    .be_ni   (be_ni),
    .addr_o  (addr_o),
    .be_no   (be_no)
  );

  AST_WRITE_NEVER_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !we_ni) |-> !idle); // R8
endmodule

// File: tb/addr_latch_ctrl_tb.sv
module addr_latch_ctrl_tb;
  localparam int unsigned AW = 20;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cs_ni = 1'b1, oe_ni = 1'b1, we_ni = 1'b1;
  logic [1:0]    mode_i = 2'd0;
  logic          dly_en_i = 1'b1;
  logic [2:0]    dly_i = 3'd0;
  logic          be_latch_en_i = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [1:0]    be_ni = 2'b11;
  logic [AW-1:0] addr_o;
  logic [1:0]    be_no;
  logic          hold_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  addr_latch_ctrl u_dut (
    .clk_i, .rst_ni, .cs_ni, .oe_ni, .we_ni, .mode_i, .dly_en_i, .dly_i,
    .be_latch_en_i, .addr_i, .be_ni, .addr_o, .be_no, .hold_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic strobes(input logic cs, input logic oe, input logic we);
    cs_ni = cs; oe_ni = oe; we_ni = we;
  endtask

  // load config with strobes idle; two edges return the sequencer to idle
  task automatic set_cfg(input logic [1:0] m, input logic den, input logic [2:0] d, input logic been);
    strobes(1, 1, 1);
    mode_i = m; dly_en_i = den; dly_i = d; be_latch_en_i = been;
    step(); step();
  endtask

  task automatic t_reset();
    addr_i = 20'h1234A; be_ni = 2'b01;
    #1;
    chk("R1 hold in reset", 32'(hold_o), 0);
    chk("R1 addr in reset", 32'(addr_o), 32'h1234A);
    rst_ni = 1'b1;
    step();
    chk("R1 hold after reset", 32'(hold_o), 0);
    addr_i = 20'h00055; be_ni = 2'b10;
    #1;
    chk("R2 addr transparent", 32'(addr_o), 32'h00055);
    chk("R2 be transparent", 32'(be_no), 32'h2);
  endtask

  task automatic t_default_write();
    set_cfg(2'd0, 1, 3'd0, 1);
    addr_i = 20'hA0001;
    strobes(0, 1, 0);
    step();
    chk("R9 min delay not yet", 32'(hold_o), 0);
    step();
    chk("R4 R9 hold at edge 2", 32'(hold_o), 1);
    addr_i = 20'hB0002;
    #1;
    chk("R3 addr frozen", 32'(addr_o), 32'hA0001);
    step();
    chk("R3 still frozen", 32'(addr_o), 32'hA0001);
    strobes(0, 1, 1);
    step();
    chk("R11 hold released", 32'(hold_o), 0);
    chk("R11 transparent", 32'(addr_o), 32'hB0002);
  endtask

  task automatic t_default_read();
    set_cfg(2'd0, 0, 3'd0, 1);
    strobes(0, 0, 1);
    step(); step();
    chk("R4 read does not freeze", 32'(hold_o), 0);
  endtask

  task automatic t_delay5();
    set_cfg(2'd1, 1, 3'd5, 1);
    addr_i = 20'h00777;
    strobes(0, 1, 1);
    for (int i = 0; i < 5; i++) step();
    chk("R9 delay 5 not yet", 32'(hold_o), 0);
    step();
    chk("R9 delay 5 hold", 32'(hold_o), 1);
    chk("R9 captured addr", 32'(addr_o), 32'h00777);
  endtask

  task automatic t_abort();
    set_cfg(2'd1, 1, 3'd5, 1);
    strobes(0, 1, 1);
    step(); step();
    strobes(1, 1, 1);
    for (int i = 0; i < 6; i++) begin
      step();
      chk("R10 aborted no hold", 32'(hold_o), 0);
    end
  endtask

  task automatic t_nodelay_cs_only();
    set_cfg(2'd1, 0, 3'd7, 1);
    addr_i = 20'h00100;
    strobes(0, 1, 1);
    step();
    chk("R5 R9 cs only immediate", 32'(hold_o), 1);
    chk("R5 captured", 32'(addr_o), 32'h00100);
  endtask

  task automatic t_any();
    set_cfg(2'd2, 0, 3'd0, 1);
    strobes(0, 1, 1);
    step();
    chk("R6 cs alone no hold", 32'(hold_o), 0);
    strobes(0, 0, 1);
    step();
    chk("R6 cs and oe hold", 32'(hold_o), 1);
  endtask

  task automatic t_not_oe();
    set_cfg(2'd3, 0, 3'd0, 1);
    addr_i = 20'h0C0C0;
    strobes(0, 1, 1);
    step();
    chk("R7 cs hold", 32'(hold_o), 1);
    addr_i = 20'h0D0D0;
    #1;
    chk("R7 frozen", 32'(addr_o), 32'h0C0C0);
    strobes(0, 0, 1);
    step();
    chk("R7 oe releases", 32'(hold_o), 0);
    chk("R7 transparent", 32'(addr_o), 32'h0D0D0);
    step();
    chk("R7 stays released", 32'(hold_o), 0);
    strobes(0, 0, 0);
    step();
    chk("R8 write with oe in mode 3", 32'(hold_o), 1);
  endtask

  task automatic t_be();
    set_cfg(2'd0, 0, 3'd0, 1);
    be_ni = 2'b10; addr_i = 20'h00011;
    strobes(0, 1, 0);
    step();
    be_ni = 2'b01;
    #1;
    chk("R12 be frozen", 32'(be_no), 32'h2);
    set_cfg(2'd0, 0, 3'd0, 0);
    be_ni = 2'b10;
    strobes(0, 1, 0);
    step();
    be_ni = 2'b01; addr_i = 20'h00022;
    #1;
    chk("R12 be transparent", 32'(be_no), 32'h1);
    chk("R12 addr still frozen", 32'(addr_o), 32'h00011);
  endtask

  task automatic t_mode_change();
    set_cfg(2'd0, 0, 3'd0, 1);
    strobes(0, 1, 0);
    step();
    chk("R13 hold start", 32'(hold_o), 1);
    mode_i = 2'd1;
    step();
    strobes(0, 1, 1);
    step();
    chk("R13 old mode releases", 32'(hold_o), 0);
    step(); step();
    chk("R13 new mode applies later", 32'(hold_o), 1);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    t_default_write();
    t_default_read();
    t_delay5();
    t_abort();
    t_nodelay_cs_only();
    t_any();
    t_not_oe();
    t_be();
    t_mode_change();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule